// File: doc/BRIEF.md
# Reset Sequencer with Glitch Filter and Indication Output

This block sequences the system reset of a microcontroller-class chip. An active-low reset pin is brought into the clock domain through a short synchronizer chain. It then passes through a saturating low-level counter, so that brief dips on the pin never reach the chip. An accepted pin reset, a software reset request and a watchdog reset request are merged into one internal core reset. That core reset is held for a fixed number of cycles after the last source goes away.

Alongside the core reset, the block drives a reset indication flag for the board. A filtered pin reset raises the flag on the very edge that accepts the pin. Software and watchdog resets raise it only when a configuration bit asks for it. Three events can lower the flag: the end-of-initialization event, a software release pulse, or, when selected, the cycle in which the core reset ends.

The block also qualifies a power-down request. The request becomes a one-cycle power-down entry strobe only when the synchronized non-maskable interrupt pin is low. Otherwise it is ignored and operation continues. A separate power-on reset input initializes the sequencer itself, and the sequencer comes out of power-on with both resets asserted.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `porN` is low and after its release, `coreReset` and `resetOut` are 1 and `powerDownEnter` is 0. `coreReset` stays 1 for HOLD_CYC clock edges after `porN` rises.
- R2: A low run on `rstPinN` covering fewer than FILT_CYC consecutive rising edges changes none of the outputs.
- R3: A low run on `rstPinN` covering at least FILT_CYC edges is accepted. `resetOut` becomes 1 after edge SYNC_STAGES+FILT_CYC, counted from the first low-sampling edge. `coreReset` follows one edge later.
- R4: `coreReset` deasserts exactly HOLD_CYC edges after the edge at which the last reset source was last seen active. No edge in between may see a source active.
- R5: A `swResetReq` or `wdtResetReq` sampled at an edge sets `coreReset` after that edge and keeps it high for HOLD_CYC cycles.
- R6: A software or watchdog request raises `resetOut` only when `cfgIntRstOut` is 1. With `cfgIntRstOut` at 0, `resetOut` stays 0.
- R7: An `initDone` pulse clears `resetOut` at the sampling edge.
- R8: A `swRelease` pulse clears `resetOut` at the sampling edge.
- R9: With `cfgReleaseAtEnd` at 1, `resetOut` clears on the same edge at which `coreReset` falls. With it at 0, `resetOut` stays 1.
- R10: When a flag-setting event and a flag-clearing event are sampled at the same edge, the flag is set.
- R11: A `pwrdnReq` pulse yields a one-cycle `powerDownEnter` pulse after the sampling edge only if synchronized `nmiPin` is 0. With `nmiPin` at 1, `powerDownEnter` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porN | input | 1 | Asynchronous power-on reset of the sequencer, active low |
| rstPinN | input | 1 | Raw external reset pin, active low, asynchronous |
| swResetReq | input | 1 | Software reset request, one-cycle pulse |
| wdtResetReq | input | 1 | Watchdog reset request, one-cycle pulse |
| initDone | input | 1 | End-of-initialization event, one-cycle pulse |
| swRelease | input | 1 | Software release of the indication flag, pulse |
| cfgIntRstOut | input | 1 | 1: software/watchdog resets raise the indication flag |
| cfgReleaseAtEnd | input | 1 | 1: indication flag drops when core reset ends |
| nmiPin | input | 1 | Non-maskable interrupt pin level, asynchronous |
| pwrdnReq | input | 1 | Power-down request, one-cycle pulse |
| coreReset | output | 1 | Internal reset, active high |
| resetOut | output | 1 | External reset indication, active high |
| powerDownEnter | output | 1 | One-cycle strobe to enter power-down |

## Verification
Two functions can act on the same edge. A reset request can set the indication flag while a release event tries to clear it, and the end-of-reset release can coincide with the fall of the core reset. The first case is provoked by pulsing `swResetReq` and `initDone` together with `cfgIntRstOut` at 1. The bench expects `resetOut` high on the following cycle. The second case is judged by expecting `coreReset` and `resetOut` to be high together one cycle before the end and low together on the next cycle.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  // Strobes issued by the control to the datapath each cycle
  typedef struct packed {
    logic loadHold;  // reload the stretch counter
    logic decHold;   // count the stretch counter down
    logic setOut;    // raise the indication flag
    logic clrOut;    // lower the indication flag
    logic pdEnter;   // qualified power-down entry
  } rstcStrobes_t;
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic porN,
  input  logic dIn,
  output logic qOut
);
  logic [STAGES-1:0] stg;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      stg <= {STAGES{RESET_VAL}};
    end else begin
      stg[0] <= dIn;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign qOut = stg[STAGES-1];
endmodule

// File: rtl/rstc_datapath.sv
module rstc_datapath
  import rstc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 10,
  parameter int HOLD_CYC    = 8
) (
  input  logic         clk,
  input  logic         porN,
  input  logic         rstPinN,
  input  logic         nmiPin,
  input  rstcStrobes_t strb,
  output logic         pinActive,
  output logic         nmiLow,
  output logic         holdZero,
  output logic         holdOne,
  output logic         coreReset,
  output logic         resetOut,
  output logic         powerDownEnter
);
  localparam int FILT_W = $clog2(FILT_CYC + 1);
  localparam int HOLD_W = $clog2(HOLD_CYC + 1);
  localparam logic [FILT_W-1:0] FILT_MAX = FILT_W'(FILT_CYC);
  localparam logic [HOLD_W-1:0] HOLD_MAX = HOLD_W'(HOLD_CYC);

  logic              pinSync;
  logic              nmiSync;
  logic [FILT_W-1:0] lowCnt;
  logic [HOLD_W-1:0] holdCnt;
  logic              outFlag;
  logic              pdQ;

  rstc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) pinSync_i (
    .clk(clk), .porN(porN), .dIn(rstPinN), .qOut(pinSync)
  );

  rstc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) nmiSync_i (
    .clk(clk), .porN(porN), .dIn(nmiPin), .qOut(nmiSync)
  );

  // Low-level filter: counts low samples, saturates, any high sample clears
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      lowCnt <= '0;
    end else if (pinSync) begin
      lowCnt <= '0;
    end else if (lowCnt != FILT_MAX) begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  // Stretch counter: nonzero means core reset asserted
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      holdCnt <= HOLD_MAX;
    end else if (strb.loadHold) begin
      holdCnt <= HOLD_MAX;
    end else if (strb.decHold) begin
      holdCnt <= holdCnt - 1'b1;
    end
  end

  // Indication flag, set dominates clear
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      outFlag <= 1'b1;
    end else if (strb.setOut) begin
      outFlag <= 1'b1;
    end else if (strb.clrOut) begin
      outFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) pdQ <= 1'b0;
    else       pdQ <= strb.pdEnter;
  end

  assign pinActive      = (lowCnt == FILT_MAX);
  assign nmiLow         = !nmiSync;
  assign holdZero       = (holdCnt == '0);
  assign holdOne        = (holdCnt == HOLD_W'(1));
  assign coreReset      = !holdZero;
  assign resetOut       = outFlag | pinActive;
  assign powerDownEnter = pdQ;
endmodule

// File: rtl/rstc_control.sv
module rstc_control
  import rstc_pkg::*;
(
  input  logic         pinActive,
  input  logic         nmiLow,
  input  logic         holdZero,
  input  logic         holdOne,
  input  logic         swResetReq,
  input  logic         wdtResetReq,
  input  logic         initDone,
  input  logic         swRelease,
  input  logic         cfgIntRstOut,
  input  logic         cfgReleaseAtEnd,
  input  logic         pwrdnReq,
  output rstcStrobes_t strb
);
  logic intReq;
  logic anySrc;
  logic endOfReset;
  logic relEvent;

  always_comb begin
    intReq     = swResetReq | wdtResetReq;
    anySrc     = pinActive | intReq;
    endOfReset = !anySrc && !holdZero && holdOne;
    relEvent   = initDone | swRelease | (cfgReleaseAtEnd & endOfReset);

    strb.loadHold = anySrc;
    strb.decHold  = !anySrc && !holdZero;
    strb.setOut   = pinActive | (cfgIntRstOut & intReq);
    strb.clrOut   = !strb.setOut && relEvent;
    strb.pdEnter  = pwrdnReq & nmiLow;
  end
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rstc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 10,
  parameter int HOLD_CYC    = 8
) (
  input  logic clk,
  input  logic porN,
  input  logic rstPinN,
  input  logic swResetReq,
  input  logic wdtResetReq,
  input  logic initDone,
  input  logic swRelease,
  input  logic cfgIntRstOut,
  input  logic cfgReleaseAtEnd,
  input  logic nmiPin,
  input  logic pwrdnReq,
  output logic coreReset,
  output logic resetOut,
  output logic powerDownEnter
);
  rstcStrobes_t strb;
  logic pinActive;
  logic nmiLow;
  logic holdZero;
  logic holdOne;

  rstc_control ctrl_i (
    .pinActive(pinActive), .nmiLow(nmiLow), .holdZero(holdZero), .holdOne(holdOne),
    .swResetReq(swResetReq), .wdtResetReq(wdtResetReq), .initDone(initDone),
    .swRelease(swRelease), .cfgIntRstOut(cfgIntRstOut),
    .cfgReleaseAtEnd(cfgReleaseAtEnd), .pwrdnReq(pwrdnReq), .strb(strb)
  );

  rstc_datapath #(
    .SYNC_STAGES(SYNC_STAGES), .FILT_CYC(FILT_CYC), .HOLD_CYC(HOLD_CYC)
  ) dp_i (
    .clk(clk), .porN(porN), .rstPinN(rstPinN), .nmiPin(nmiPin), .strb(strb),
    .pinActive(pinActive), .nmiLow(nmiLow), .holdZero(holdZero), .holdOne(holdOne),
    .coreReset(coreReset), .resetOut(resetOut), .powerDownEnter(powerDownEnter)
  );
endmodule

// File: rtl/rst_seq_ctrl_chk.sv
module rst_seq_ctrl_chk (
  input logic clk,
  input logic porN,
  input logic swResetReq,
  input logic wdtResetReq,
  input logic cfgIntRstOut,
  input logic pwrdnReq,
  input logic pinActive,
  input logic nmiLow,
  input logic coreReset,
  input logic resetOut,
  input logic powerDownEnter
);
  // R3: an accepted pin reset reaches the core reset on the next edge
  a_r3_pin_to_core: assert property (@(posedge clk) disable iff (!porN)
    pinActive |=> coreReset);

  // R4: core reset only falls after a cycle with no active source
  a_r4_quiet_before_fall: assert property (@(posedge clk) disable iff (!porN)
    $fell(coreReset) |-> $past(!pinActive && !swResetReq && !wdtResetReq));

  // R5: an internal request starts the core reset
  a_r5_req_starts_reset: assert property (@(posedge clk) disable iff (!porN)
    (swResetReq || wdtResetReq) |=> coreReset);

  // R6: with the option off, only the pin can raise the indication
  a_r6_no_int_indication: assert property (@(posedge clk) disable iff (!porN)
    (!resetOut && !cfgIntRstOut) |=> (!resetOut || pinActive));

  // R10: a set request wins over any release in the same cycle
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!porN)
    (cfgIntRstOut && (swResetReq || wdtResetReq)) |=> resetOut);

  // R11: qualified request produces the strobe
  a_r11_pd_enter: assert property (@(posedge clk) disable iff (!porN)
    (pwrdnReq && nmiLow) |=> powerDownEnter);

  // R11: strobe never appears without a qualified request
  a_r11_pd_qualified: assert property (@(posedge clk) disable iff (!porN)
    powerDownEnter |-> $past(pwrdnReq && nmiLow));
endmodule

bind rst_seq_ctrl rst_seq_ctrl_chk chk_i (
  .clk(clk), .porN(porN), .swResetReq(swResetReq), .wdtResetReq(wdtResetReq),
  .cfgIntRstOut(cfgIntRstOut), .pwrdnReq(pwrdnReq), .pinActive(pinActive),
  .nmiLow(nmiLow), .coreReset(coreReset), .resetOut(resetOut),
  .powerDownEnter(powerDownEnter)
);

// File: tb/rst_seq_ctrl_tb_top.sv
module rst_seq_ctrl_tb_top;
  localparam int FILT = 10;
  localparam int HOLD = 8;

  logic clk = 1'b0;
  logic porN, rstPinN, swResetReq, wdtResetReq, initDone, swRelease;
  logic cfgIntRstOut, cfgReleaseAtEnd, nmiPin, pwrdnReq;
  logic coreReset, resetOut, powerDownEnter;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    int    cyc;
    logic  cr;
    logic  ro;
    logic  pd;
    string tag;
  } exp_t;

  exp_t expQ[$];
  exp_t e;

  rst_seq_ctrl #(.SYNC_STAGES(2), .FILT_CYC(FILT), .HOLD_CYC(HOLD)) dut_i (
    .clk(clk), .porN(porN), .rstPinN(rstPinN), .swResetReq(swResetReq),
    .wdtResetReq(wdtResetReq), .initDone(initDone), .swRelease(swRelease),
    .cfgIntRstOut(cfgIntRstOut), .cfgReleaseAtEnd(cfgReleaseAtEnd),
    .nmiPin(nmiPin), .pwrdnReq(pwrdnReq), .coreReset(coreReset),
    .resetOut(resetOut), .powerDownEnter(powerDownEnter)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compares outputs with the expectations due in this cycle
  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].cyc <= cyc) begin
      e = expQ.pop_front();
      checks++;
      if (e.cyc != cyc || {coreReset, resetOut, powerDownEnter} !== {e.cr, e.ro, e.pd}) begin
        failures++;
        $display("FAIL %s cyc=%0d actual cr/ro/pd=%b%b%b expected=%b%b%b (due cyc %0d)",
                 e.tag, cyc, coreReset, resetOut, powerDownEnter, e.cr, e.ro, e.pd, e.cyc);
      end
    end
  end

  task automatic expectAt(int dc, logic cr, logic ro, logic pd, string tag);
    exp_t n;
    n.cyc = cyc + dc; n.cr = cr; n.ro = ro; n.pd = pd; n.tag = tag;
    expQ.push_back(n);
  endtask

  task automatic checkNow(logic cr, logic ro, logic pd, string tag);
    checks++;
    if ({coreReset, resetOut, powerDownEnter} !== {cr, ro, pd}) begin
      failures++;
      $display("FAIL %s actual cr/ro/pd=%b%b%b expected=%b%b%b",
               tag, coreReset, resetOut, powerDownEnter, cr, ro, pd);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    porN = 1'b0; rstPinN = 1'b1; swResetReq = 1'b0; wdtResetReq = 1'b0;
    initDone = 1'b0; swRelease = 1'b0; cfgIntRstOut = 1'b0;
    cfgReleaseAtEnd = 1'b1; nmiPin = 1'b1; pwrdnReq = 1'b0;

    // R1: reset state, then the power-on stretch; R9 release with it
    waitCyc(3);
    checkNow(1'b1, 1'b1, 1'b0, "R1 reset state");
    porN = 1'b1;
    expectAt(HOLD - 1, 1'b1, 1'b1, 1'b0, "R1 stretch last cycle");
    expectAt(HOLD, 1'b0, 1'b0, 1'b0, "R1 R9 end of power-on reset");
    waitCyc(HOLD + 2);
    cfgReleaseAtEnd = 1'b0;

    // R2: low run one sample too short
    step();
    rstPinN = 1'b0;
    expectAt(FILT + 1, 1'b0, 1'b0, 1'b0, "R2 short pulse");
    expectAt(FILT + 2, 1'b0, 1'b0, 1'b0, "R2 short pulse");
    expectAt(FILT + 4, 1'b0, 1'b0, 1'b0, "R2 short pulse");
    waitCyc(FILT - 1);
    rstPinN = 1'b1;
    waitCyc(8);

    // R3 and R4: accepted pin reset and its stretch
    step();
    rstPinN = 1'b0;
    expectAt(FILT + 1, 1'b0, 1'b0, 1'b0, "R3 before acceptance");
    expectAt(FILT + 2, 1'b0, 1'b1, 1'b0, "R3 indication on acceptance");
    expectAt(FILT + 3, 1'b1, 1'b1, 1'b0, "R3 core reset");
    expectAt(FILT + 5 + 10, 1'b1, 1'b1, 1'b0, "R4 stretch last cycle");
    expectAt(FILT + 5 + 11, 1'b0, 1'b1, 1'b0, "R4 core reset falls");
    waitCyc(FILT + 5);
    rstPinN = 1'b1;
    waitCyc(14);

    // R7: end-of-init event releases the indication
    step();
    initDone = 1'b1;
    expectAt(1, 1'b0, 1'b0, 1'b0, "R7 release on init done");
    step();
    initDone = 1'b0;
    waitCyc(2);

    // R5 and R6: software reset without indication
    step();
    swResetReq = 1'b1;
    expectAt(1, 1'b1, 1'b0, 1'b0, "R5 R6 sw reset no indication");
    expectAt(HOLD, 1'b1, 1'b0, 1'b0, "R5 sw reset length");
    expectAt(HOLD + 1, 1'b0, 1'b0, 1'b0, "R5 sw reset end");
    step();
    swResetReq = 1'b0;
    waitCyc(HOLD + 2);

    // R6: watchdog reset with indication enabled
    cfgIntRstOut = 1'b1;
    step();
    wdtResetReq = 1'b1;
    expectAt(1, 1'b1, 1'b1, 1'b0, "R6 wdt reset raises indication");
    expectAt(HOLD + 1, 1'b0, 1'b1, 1'b0, "R5 wdt reset end, R9 option off");
    step();
    wdtResetReq = 1'b0;
    waitCyc(HOLD + 2);

    // R8: software release
    step();
    swRelease = 1'b1;
    expectAt(1, 1'b0, 1'b0, 1'b0, "R8 software release");
    step();
    swRelease = 1'b0;
    waitCyc(2);

    // R9: release at end of reset
    cfgReleaseAtEnd = 1'b1;
    step();
    swResetReq = 1'b1;
    expectAt(1, 1'b1, 1'b1, 1'b0, "R9 start");
    expectAt(HOLD, 1'b1, 1'b1, 1'b0, "R9 both high before end");
    expectAt(HOLD + 1, 1'b0, 1'b0, 1'b0, "R9 both fall together");
    step();
    swResetReq = 1'b0;
    waitCyc(HOLD + 2);

    // R10: set and release on the same edge
    step();
    swResetReq = 1'b1;
    initDone = 1'b1;
    expectAt(1, 1'b1, 1'b1, 1'b0, "R10 set wins");
    expectAt(HOLD + 1, 1'b0, 1'b0, 1'b0, "R10 later end release");
    step();
    swResetReq = 1'b0;
    initDone = 1'b0;
    waitCyc(HOLD + 2);

    // R11: power-down blocked by NMI high, then allowed
    step();
    pwrdnReq = 1'b1;
    expectAt(1, 1'b0, 1'b0, 1'b0, "R11 blocked by nmi high");
    expectAt(2, 1'b0, 1'b0, 1'b0, "R11 blocked by nmi high");
    step();
    pwrdnReq = 1'b0;
    nmiPin = 1'b0;
    waitCyc(4);
    pwrdnReq = 1'b1;
    expectAt(1, 1'b0, 1'b0, 1'b1, "R11 enter power-down");
    expectAt(2, 1'b0, 1'b0, 1'b0, "R11 single-cycle strobe");
    step();
    pwrdnReq = 1'b0;
    waitCyc(4);

    if (expQ.size() != 0) begin
      failures += expQ.size();
      checks += expQ.size();
      $display("FAIL scoreboard R1 actual pending=%0d expected=0", expQ.size());
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule